// File: doc/BRIEF.md
# Linked Breakpoint Comparator Bank

This block holds a small bank of instruction breakpoint pairs. Each pair has a 32-bit value register and a control register. Every cycle, each pair compares its value against the current instruction address or the current context ID, as its control register directs. The bank raises one debug-event flag when any pair matches.

An address compare can ignore a programmable number of low address bits, so one pair can cover an aligned range. A pair can fire on an equal address or on a differing address. A pair can also fire on a context-ID match. In the linked address forms, a pair fires only when a second pair it names is set up as a context-ID qualifier and that qualifier matches the current context ID. Every combination whose result would otherwise be undefined is resolved to "no event".

Software programs the bank through a plain indexed write port. Reads use a combinational read-data path. The event flag is registered and follows the address-valid strobe by one clock.

The block has no state machine. Its only sequential behaviour is the configuration storage and the single event register, which has two states: idle (flag low) and fired (flag high). The transition from idle to fired is taken at an edge where the address-valid input is high and at least one pair fires. The transition back to idle is taken at any edge where that condition does not hold.

Top module: `bkpt_bank`

## Requirements
- R1: After reset, every value and control register reads zero and `dbg_event` is low.
- R2: A value register reads back all 32 written bits. A control register keeps only these fields: mask count in bits [28:24], mode in bits [22:20], link index in bits [19:16] and enable in bit 0. All other bits read zero. Read data is combinational on `cfg_idx`/`cfg_sel`, where `cfg_sel` = 1 selects the control register and 0 selects the value register.
- R3: In mode 000 with mask count 0, an enabled pair fires when the instruction address equals its value exactly.
- R4: A mask count n from 3 to 31 excludes the low n address bits from the compare. A count of 1 or 2 is reserved, and a pair holding such a count never fires.
- R5: In mode 100, the pair fires when the masked address differs from the masked value.
- R6: In mode 010, the pair fires when the context ID equals its value.
- R7: Modes 001 (linked equal) and 101 (linked differ) fire only when the address condition holds and the pair named by the link index is enabled, in mode 011, and its value equals the context ID.
- R8: Mode 011 never fires by itself. Modes 110 and 111 never fire.
- R9: A linked pair that names itself, names a pair not in mode 011, or names an index of 4 or higher never fires.
- R10: A pair whose enable bit is clear never fires and never qualifies a linked pair.
- R11: `dbg_event` is high in the cycle after a cycle in which `iaddr_vld` was high and some pair fired. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Pair index |
| cfg_sel | input | 1 | 1 selects the control register, 0 selects the value register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data |
| iaddr | input | 32 | Current instruction address |
| iaddr_vld | input | 1 | Address is valid this cycle |
| ctx_id | input | 32 | Current context ID |
| dbg_event | output | 1 | Registered debug-event flag |

## Verification
Stored configuration is visible on `cfg_rdata` in the cycle after a write, so a corrupted register shows up at once on readback. A wrong compare result or a wrong link resolution shows up on `dbg_event` exactly one clock after the strobed address. For that reason, every stimulus vector is checked at that single cycle, and a flag that arrives late or early is caught as a miss. The linked cases are checked in pairs: the qualifier is present in one vector and absent in the next, which exposes a link that ignores its target.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int DW     = 32;
    localparam int LINK_W = 4;

    // control register bits kept on write
    localparam logic [DW-1:0] CTL_KEEP = 32'h1F7F_0001;

    typedef enum logic [2:0] {
        MODE_ADDR     = 3'b000,
        MODE_ADDR_LNK = 3'b001,
        MODE_CTX      = 3'b010,
        MODE_CTX_LNK  = 3'b011,
        MODE_MISS     = 3'b100,
        MODE_MISS_LNK = 3'b101,
        MODE_RSV6     = 3'b110,
        MODE_RSV7     = 3'b111
    } bp_mode_e;

    typedef struct packed {
        logic [4:0]        mask_cnt;
        bp_mode_e          mode;
        logic [LINK_W-1:0] link;
        logic              en;
    } bp_ctl_t;

    function automatic logic [DW-1:0] ctl_pack(input bp_ctl_t c);
        logic [DW-1:0] w;
        w        = '0;
        w[28:24] = c.mask_cnt;
        w[22:20] = c.mode;
        w[19:16] = c.link;
        w[0]     = c.en;
        return w;
    endfunction

    function automatic bp_ctl_t ctl_unpack(input logic [DW-1:0] w);
        bp_ctl_t c;
        c.mask_cnt = w[28:24];
        c.mode     = bp_mode_e'(w[22:20]);
        c.link     = w[19:16];
        c.en       = w[0];
        return c;
    endfunction

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter  int NUM_PAIRS = 4,
    localparam int IDX_W     = $clog2(NUM_PAIRS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_idx,
    input  logic                           cfg_sel,
    input  logic [DW-1:0]                  cfg_wdata,
    output logic [DW-1:0]                  cfg_rdata,
    output logic [NUM_PAIRS-1:0][DW-1:0]   val_o,
    output bp_ctl_t [NUM_PAIRS-1:0]        ctl_o
);

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic [DW-1:0] val_q;
        bp_ctl_t       ctl_q;
        logic          hit_idx;

        assign hit_idx = (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                ctl_q <= '0;
            end else if (cfg_we && hit_idx) begin
                if (cfg_sel) ctl_q <= ctl_unpack(cfg_wdata);
                else         val_q <= cfg_wdata;
            end
        end

        assign val_o[g] = val_q;
        assign ctl_o[g] = ctl_q;
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (cfg_idx == IDX_W'(i))
                cfg_rdata = cfg_sel ? ctl_pack(ctl_o[i]) : val_o[i];
        end
    end

endmodule

// File: rtl/bkpt_pair_cmp.sv
module bkpt_pair_cmp
    import bkpt_pkg::*;
(
    input  logic [DW-1:0]     val,
    input  bp_ctl_t           ctl,
    input  logic [DW-1:0]     iaddr,
    input  logic [DW-1:0]     ctx_id,
    output logic              hit_direct,
    output logic              hit_linked,
    output logic              qual,
    output logic [LINK_W-1:0] link_tgt
);

    logic [DW-1:0] ign_bits;
    logic          cnt_ok;
    logic          live;
    logic          addr_eq;
    logic          ctx_eq;

    assign ign_bits = (ctl.mask_cnt == 5'd0) ? '0
                    : ((DW'(1) << ctl.mask_cnt) - DW'(1));
    assign cnt_ok   = (ctl.mask_cnt != 5'd1) && (ctl.mask_cnt != 5'd2);
    assign live     = ctl.en && cnt_ok;
    assign addr_eq  = ((iaddr ^ val) & ~ign_bits) == '0;
    assign ctx_eq   = (ctx_id == val);
    assign link_tgt = ctl.link;

    always_comb begin
        hit_direct = 1'b0;
        hit_linked = 1'b0;
        qual       = 1'b0;
        unique case (ctl.mode)
            MODE_ADDR:     hit_direct = live && addr_eq;
            MODE_ADDR_LNK: hit_linked = live && addr_eq;
            MODE_CTX:      hit_direct = live && ctx_eq;
            MODE_CTX_LNK:  qual       = live && ctx_eq;
            MODE_MISS:     hit_direct = live && !addr_eq;
            MODE_MISS_LNK: hit_linked = live && !addr_eq;
            MODE_RSV6, MODE_RSV7: ;
        endcase
    end

endmodule

// File: rtl/bkpt_link_merge.sv
module bkpt_link_merge
    import bkpt_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               iaddr_vld,
    input  logic [NUM_PAIRS-1:0]               hit_direct,
    input  logic [NUM_PAIRS-1:0]               hit_linked,
    input  logic [NUM_PAIRS-1:0]               qual,
    input  logic [NUM_PAIRS-1:0][LINK_W-1:0]   link_tgt,
    output logic                               dbg_event
);

    logic [NUM_PAIRS-1:0] tgt_ok;
    logic [NUM_PAIRS-1:0] fire;

    always_comb begin
        for (int i = 0; i < NUM_PAIRS; i++) begin
            tgt_ok[i] = 1'b0;
            for (int j = 0; j < NUM_PAIRS; j++) begin
                if (j != i && link_tgt[i] == LINK_W'(j))
                    tgt_ok[i] = qual[j];
            end
            fire[i] = hit_direct[i] || (hit_linked[i] && tgt_ok[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dbg_event <= 1'b0;
        else        dbg_event <= iaddr_vld && (|fire);
    end

endmodule

// File: rtl/bkpt_bank.sv
module bkpt_bank
    import bkpt_pkg::*;
#(
    parameter  int NUM_PAIRS = 4,
    localparam int IDX_W     = $clog2(NUM_PAIRS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [31:0]      iaddr,
    input  logic             iaddr_vld,
    input  logic [31:0]      ctx_id,
    output logic             dbg_event
);

    logic [NUM_PAIRS-1:0][DW-1:0]     pair_val;
    bp_ctl_t [NUM_PAIRS-1:0]          pair_ctl;
    logic [NUM_PAIRS-1:0]             pair_en;
    logic [NUM_PAIRS-1:0]             hit_direct;
    logic [NUM_PAIRS-1:0]             hit_linked;
    logic [NUM_PAIRS-1:0]             qual;
    logic [NUM_PAIRS-1:0][LINK_W-1:0] link_tgt;

    bkpt_regfile #(.NUM_PAIRS(NUM_PAIRS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .val_o     (pair_val),
        .ctl_o     (pair_ctl)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_cmp
        assign pair_en[g] = pair_ctl[g].en;
        bkpt_pair_cmp cmp_i (
            .val        (pair_val[g]),
            .ctl        (pair_ctl[g]),
            .iaddr      (iaddr),
            .ctx_id     (ctx_id),
            .hit_direct (hit_direct[g]),
            .hit_linked (hit_linked[g]),
            .qual       (qual[g]),
            .link_tgt   (link_tgt[g])
        );
    end

    bkpt_link_merge #(.NUM_PAIRS(NUM_PAIRS)) merge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .iaddr_vld  (iaddr_vld),
        .hit_direct (hit_direct),
        .hit_linked (hit_linked),
        .qual       (qual),
        .link_tgt   (link_tgt),
        .dbg_event  (dbg_event)
    );

endmodule

// File: rtl/bkpt_bank_chk.sv
module bkpt_bank_chk
    import bkpt_pkg::*;
#(
    parameter  int NUM_PAIRS = 4,
    localparam int IDX_W     = $clog2(NUM_PAIRS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [IDX_W-1:0]     cfg_idx,
    input logic                 cfg_sel,
    input logic [31:0]          cfg_wdata,
    input logic [31:0]          cfg_rdata,
    input logic                 iaddr_vld,
    input logic                 dbg_event,
    input logic [NUM_PAIRS-1:0] pair_en
);

    p_event_after_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_event |-> $past(iaddr_vld));

    p_ctl_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> ((cfg_rdata & ~CTL_KEEP) == '0));

    p_val_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=>
            (cfg_sel || cfg_idx != $past(cfg_idx) || cfg_rdata == $past(cfg_wdata)));

    p_all_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en == '0) |=> !dbg_event);

endmodule

bind bkpt_bank bkpt_bank_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .iaddr_vld (iaddr_vld),
    .dbg_event (dbg_event),
    .pair_en   (pair_en)
);

// File: tb/bkpt_bank_tb_top.sv
module bkpt_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] iaddr = '0;
    logic        iaddr_vld = 1'b0;
    logic [31:0] ctx_id = '0;
    logic        dbg_event;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bkpt_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .iaddr     (iaddr),
        .iaddr_vld (iaddr_vld),
        .ctx_id    (ctx_id),
        .dbg_event (dbg_event)
    );

    // control word: mask count [28:24], mode [22:20], link [19:16], enable [0]
    function automatic logic [31:0] mk(input int cnt, input int md, input int lk, input int en);
        return {3'b0, 5'(cnt), 1'b0, 3'(md), 4'(lk), 15'b0, 1'(en)};
    endfunction

    typedef struct packed {
        logic [31:0] c0;
        logic [31:0] v0;
        logic [31:0] c1;
        logic [31:0] v1;
        logic [31:0] addr;
        logic [31:0] ctx;
        logic        exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{mk(0,0,0,1), 32'h1000, 32'h0, 32'h0, 32'h1000, 32'h0, 1'b1},                 // R3 exact
        '{mk(0,0,0,1), 32'h1000, 32'h0, 32'h0, 32'h1004, 32'h0, 1'b0},                 // R3 differ
        '{mk(3,0,0,1), 32'h1000, 32'h0, 32'h0, 32'h1007, 32'h0, 1'b1},                 // R4 low 3 ignored
        '{mk(3,0,0,1), 32'h1000, 32'h0, 32'h0, 32'h1008, 32'h0, 1'b0},                 // R4 bit 3 compared
        '{mk(31,0,0,1), 32'h0, 32'h0, 32'h0, 32'h7FFF_FFFF, 32'h0, 1'b1},              // R4 widest
        '{mk(31,0,0,1), 32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 1'b0},              // R4 top bit
        '{mk(1,0,0,1), 32'h1000, 32'h0, 32'h0, 32'h1000, 32'h0, 1'b0},                 // R4 reserved 1
        '{mk(2,0,0,1), 32'h1000, 32'h0, 32'h0, 32'h1000, 32'h0, 1'b0},                 // R4 reserved 2
        '{mk(0,4,0,1), 32'h2000, 32'h0, 32'h0, 32'h2004, 32'h0, 1'b1},                 // R5 differs
        '{mk(0,4,0,1), 32'h2000, 32'h0, 32'h0, 32'h2000, 32'h0, 1'b0},                 // R5 equal
        '{mk(4,4,0,1), 32'h2000, 32'h0, 32'h0, 32'h200C, 32'h0, 1'b0},                 // R5 masked equal
        '{mk(4,4,0,1), 32'h2000, 32'h0, 32'h0, 32'h2010, 32'h0, 1'b1},                 // R5 masked differ
        '{mk(0,2,0,1), 32'h55, 32'h0, 32'h0, 32'h0, 32'h55, 1'b1},                     // R6 ctx equal
        '{mk(0,2,0,1), 32'h55, 32'h0, 32'h0, 32'h0, 32'h56, 1'b0},                     // R6 ctx differ
        '{mk(0,1,1,1), 32'h3000, mk(0,3,0,1), 32'h77, 32'h3000, 32'h77, 1'b1},         // R7 linked hit
        '{mk(0,1,1,1), 32'h3000, mk(0,3,0,1), 32'h77, 32'h3000, 32'h78, 1'b0},         // R7 ctx miss
        '{mk(0,1,1,1), 32'h3000, mk(0,3,0,1), 32'h77, 32'h3004, 32'h77, 1'b0},         // R7 addr miss
        '{mk(0,5,1,1), 32'h3000, mk(0,3,0,1), 32'h77, 32'h3004, 32'h77, 1'b1},         // R7 linked differ
        '{mk(0,5,1,1), 32'h3000, mk(0,3,0,1), 32'h77, 32'h3000, 32'h77, 1'b0},         // R7 linked differ, equal
        '{mk(0,1,0,1), 32'h3000, mk(0,3,0,1), 32'h77, 32'h3000, 32'h77, 1'b0},         // R9 self link
        '{mk(0,1,1,1), 32'h3000, mk(0,0,0,1), 32'h77, 32'h3000, 32'h77, 1'b0},         // R9 target not 011
        '{mk(0,1,5,1), 32'h3000, mk(0,3,0,1), 32'h77, 32'h3000, 32'h77, 1'b0},         // R9 index out of bank
        '{mk(0,1,1,1), 32'h3000, mk(0,3,0,0), 32'h77, 32'h3000, 32'h77, 1'b0},         // R10 target disabled
        '{32'h0, 32'h0, mk(0,3,0,1), 32'h77, 32'h0, 32'h77, 1'b0},                     // R8 qualifier alone
        '{mk(0,6,0,1), 32'h1000, 32'h0, 32'h0, 32'h1000, 32'h0, 1'b0},                 // R8 mode 110
        '{mk(0,0,0,0), 32'h1000, 32'h0, 32'h0, 32'h1000, 32'h0, 1'b0}                  // R10 disabled
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int idx, input logic sel, output logic [31:0] d);
        @(negedge clk);
        cfg_idx = 2'(idx); cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    // strobe one address; result sampled at the next falling edge
    task automatic strobe(input logic [31:0] a, input logic [31:0] c, input logic v, output logic ev);
        @(negedge clk);
        iaddr = a; ctx_id = c; iaddr_vld = v;
        @(negedge clk);
        iaddr_vld = 1'b0;
        ev = dbg_event;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        ev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 event", {31'b0, dbg_event}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(i, 1'b0, r); check("R1 value", r, 32'h0);
            rd(i, 1'b1, r); check("R1 control", r, 32'h0);
        end

        // R2: readback and reserved control bits
        wr(2, 1'b0, 32'hDEAD_BEEF);
        rd(2, 1'b0, r); check("R2 value readback", r, 32'hDEAD_BEEF);
        wr(2, 1'b1, 32'hFFFF_FFFE);
        rd(2, 1'b1, r); check("R2 control keep", r, 32'h1F7F_0000);
        wr(2, 1'b1, 32'h0);
        wr(2, 1'b0, 32'h0);

        // R11: no event without valid, one-cycle latency, single pulse
        wr(0, 1'b0, 32'h4000);
        wr(0, 1'b1, mk(0,0,0,1));
        strobe(32'h4000, 32'h0, 1'b0, ev);
        check("R11 no valid", {31'b0, ev}, 32'h0);
        @(negedge clk);
        iaddr = 32'h4000; iaddr_vld = 1'b1;
        #1 check("R11 not same cycle", {31'b0, dbg_event}, 32'h0);
        @(negedge clk);
        iaddr_vld = 1'b0;
        check("R11 next cycle", {31'b0, dbg_event}, 32'h1);
        @(negedge clk);
        check("R11 drops", {31'b0, dbg_event}, 32'h0);

        // table of vectors over pairs 0 and 1
        for (int k = 0; k < NV; k++) begin
            wr(0, 1'b1, VECS[k].c0);
            wr(0, 1'b0, VECS[k].v0);
            wr(1, 1'b1, VECS[k].c1);
            wr(1, 1'b0, VECS[k].v1);
            strobe(VECS[k].addr, VECS[k].ctx, 1'b1, ev);
            check($sformatf("vector %0d (R3..R10 per table)", k), {31'b0, ev}, {31'b0, VECS[k].exp});
        end

        // R8: mode 111 never fires
        wr(1, 1'b1, 32'h0);
        wr(0, 1'b0, 32'h1000);
        wr(0, 1'b1, mk(0,7,0,1));
        strobe(32'h1000, 32'h0, 1'b1, ev);
        check("R8 mode 111", {31'b0, ev}, 32'h0);

        // R7: qualifier on pair 3 gating pair 2
        wr(0, 1'b1, 32'h0);
        wr(2, 1'b0, 32'h5000);
        wr(2, 1'b1, mk(0,1,3,1));
        wr(3, 1'b0, 32'h9);
        wr(3, 1'b1, mk(0,3,0,1));
        strobe(32'h5000, 32'h9, 1'b1, ev);
        check("R7 pair 2 to 3", {31'b0, ev}, 32'h1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule